// File: doc/BRIEF.md
# Still-Frame Camera Capture Sequencer

This block takes one still picture from a parallel 8-bit camera port and writes it into an external asynchronous SRAM. Its own clock runs at twice the camera byte rate. It never looks at the camera's pixel clock. The frame is located only from the vertical sync and line-valid strobes. Both strobes, together with the data byte, pass through a two-flop synchroniser, so the data stays aligned with the strobes.

Software pulses `arm`. The block then waits for vertical sync to go low. The next rising edge of line-valid after that opens the first line. Each byte takes two clocks. In the first clock the byte sits on the SRAM data bus while the active-low write strobe is pulsed. In the second clock the address is incremented. At that point line-valid is checked again: if it is still high, the next byte follows at once. Once a line has ended, the block waits for one of two events. A new rising edge of line-valid starts the next line. A rising edge of vertical sync ends the capture and raises `done`.

A decimation mode stores only the even-numbered lines. This lets a full-rate frame fit into a smaller memory. If the address counter reaches the top of memory, it saturates there and raises an overflow flag rather than wrapping.

Top module: `still_capture`

## Requirements
- R1: After reset, `busy`, `done` and `overflow` are 0, `sramWeN` is 1 and `sramAddr` is 0.
- R2: An `arm` accepted while not busy clears `sramAddr` to 0 and `overflow` to 0, and sets `busy` on the next clock. Line-valid pulses seen before vertical sync has gone low cause no write.
- R3: For each byte that line-valid covers, the block writes the byte values in arrival order, each with exactly one clock of `sramWeN` low. The number of writes equals the number of bytes, counted as line-valid high time divided by two clocks.
- R4: The address of each write is one higher than the address of the previous write, including across lines. The first write of a frame goes to address 0.
- R5: A rising edge of vertical sync after a line has ended sets `done` to 1 and `busy` to 0. After that, line-valid activity causes no write.
- R6: `done` stays at 1 until the next `arm`. An `arm` while busy is ignored: the address is not cleared and the capture goes on.
- R7: `decimate` is sampled when `arm` is accepted. When it is 1, only lines 0, 2, 4 and so on are written (lines counted from 0 within the frame). Odd lines produce no write and do not advance the address.
- R8: The increment that follows a write at the top address (all ones) keeps the address at the top and sets `overflow`. Later bytes overwrite the top address. `overflow` holds until the next accepted `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the camera byte rate |
| rstN | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-clock request to capture a frame |
| decimate | input | 1 | 1 = store even lines only (sampled on arm) |
| vsyncIn | input | 1 | Camera vertical sync, asynchronous |
| hrefIn | input | 1 | Camera line-valid strobe, asynchronous |
| pixData | input | DATA_W | Camera data byte |
| sramAddr | output | ADDR_W | SRAM address |
| sramData | output | DATA_W | SRAM write data |
| sramWeN | output | 1 | SRAM write strobe, active low |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Frame captured, held until next arm |
| overflow | output | 1 | Address counter saturated at the top |

## Verification
The bench targets the following cases and the failure each one would expose:
- A line-valid pulse sent while vertical sync is still high after arm. A sequencer that skipped the wait for vertical sync low would store it, and the write count would be too high.
- Random line lengths, including a single-byte line and minimum gaps between lines. These catch an off-by-one at line end, an address gap between lines, or byte data sampled out of phase with the synchronised strobe.
- Decimation, with the mode input flipped after arm. This catches odd lines leaking in, or the mode being read live instead of latched.
- A frame larger than a small memory. A counter that wraps would write back to low addresses instead of holding at the top.
- An arm issued mid-frame, and line-valid activity after done. The first shows up as a restarted address; the second as extra writes.

// File: rtl/still_capture_pkg.sv
package still_capture_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_VLOW,
    ST_WAIT_LINE,
    ST_WRITE,
    ST_STEP,
    ST_GAP,
    ST_DONE
  } capState_t;

  typedef struct packed {
    logic clearAll;
    logic latchData;
    logic writeNow;
    logic incAddr;
  } capStrobes_t;

endpackage

// File: rtl/still_capture_dp.sv
module still_capture_dp
  import still_capture_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobes_t       strobes,
  input  logic              vsyncIn,
  input  logic              hrefIn,
  input  logic [DATA_W-1:0] pixData,
  output logic              vsSync,
  output logic              hrSync,
  output logic              vsRise,
  output logic              hrRise,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              ovfQ
);

  localparam int PIPE_W = DATA_W + 2;

  logic [PIPE_W-1:0] syncPipe [SYNC_STAGES];
  logic vsPrev, hrPrev;

  // Strobes and data share one synchroniser chain so they stay aligned.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
      vsPrev <= 1'b0;
      hrPrev <= 1'b0;
    end else begin
      syncPipe[0] <= {vsyncIn, hrefIn, pixData};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      vsPrev <= vsSync;
      hrPrev <= hrSync;
    end
  end

  assign vsSync = syncPipe[SYNC_STAGES-1][DATA_W+1];
  assign hrSync = syncPipe[SYNC_STAGES-1][DATA_W];
  assign vsRise = vsSync & ~vsPrev;
  assign hrRise = hrSync & ~hrPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      ovfQ  <= 1'b0;
      dataQ <= '0;
    end else begin
      if (strobes.clearAll) begin
        addrQ <= '0;
        ovfQ  <= 1'b0;
      end else if (strobes.incAddr) begin
        if (&addrQ) ovfQ <= 1'b1;
        else        addrQ <= addrQ + 1'b1;
      end
      if (strobes.latchData) dataQ <= syncPipe[SYNC_STAGES-1][DATA_W-1:0];
    end
  end

endmodule

// File: rtl/still_capture_ctrl.sv
module still_capture_ctrl
  import still_capture_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arm,
  input  logic        decimate,
  input  logic        vsSync,
  input  logic        hrSync,
  input  logic        vsRise,
  input  logic        hrRise,
  output capStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  capState_t state, stateNext;
  logic decLatched;
  logic lineOdd;
  logic storeLine;

  assign storeLine = ~decLatched | ~lineOdd;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (arm) begin
          stateNext        = ST_WAIT_VLOW;
          strobes.clearAll = 1'b1;
        end
      end
      ST_WAIT_VLOW: begin
        if (!vsSync) stateNext = ST_WAIT_LINE;
      end
      ST_WAIT_LINE: begin
        if (hrRise) begin
          stateNext         = ST_WRITE;
          strobes.latchData = storeLine;
        end
      end
      ST_WRITE: begin
        strobes.writeNow = storeLine;
        stateNext        = ST_STEP;
      end
      ST_STEP: begin
        strobes.incAddr = storeLine;
        if (hrSync) begin
          stateNext         = ST_WRITE;
          strobes.latchData = storeLine;
        end else begin
          stateNext = ST_GAP;
        end
      end
      ST_GAP: begin
        if (vsRise) begin
          stateNext = ST_DONE;
        end else if (hrRise) begin
          stateNext         = ST_WRITE;
          strobes.latchData = storeLine;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      decLatched <= 1'b0;
      lineOdd    <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.clearAll) begin
        decLatched <= decimate;
        lineOdd    <= 1'b0;
      end else if (state == ST_STEP && !hrSync) begin
        lineOdd <= ~lineOdd;
      end
    end
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/still_capture.sv
module still_capture
  import still_capture_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic              decimate,
  input  logic              vsyncIn,
  input  logic              hrefIn,
  input  logic [DATA_W-1:0] pixData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramData,
  output logic              sramWeN,
  output logic              busy,
  output logic              done,
  output logic              overflow
);

  capStrobes_t strobes;
  logic vsSync, hrSync, vsRise, hrRise;

  still_capture_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .arm      (arm),
    .decimate (decimate),
    .vsSync   (vsSync),
    .hrSync   (hrSync),
    .vsRise   (vsRise),
    .hrRise   (hrRise),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  still_capture_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .vsyncIn (vsyncIn),
    .hrefIn  (hrefIn),
    .pixData (pixData),
    .vsSync  (vsSync),
    .hrSync  (hrSync),
    .vsRise  (vsRise),
    .hrRise  (hrRise),
    .addrQ   (sramAddr),
    .dataQ   (sramData),
    .ovfQ    (overflow)
  );

  assign sramWeN = ~strobes.writeNow;

endmodule

// File: rtl/still_capture_chk.sv
module still_capture_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              arm,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramWeN,
  input logic              busy,
  input logic              done,
  input logic              overflow
);

  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (arm && !busy) |=> (sramAddr == '0 && !overflow && busy)) else $error("AST_ARM_CLEAR"); // R2

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |=> sramWeN) else $error("AST_WE_SINGLE"); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sramAddr == $past(sramAddr) || sramAddr == ADDR_W'($past(sramAddr) + 1'b1)
              || sramAddr == '0)) else $error("AST_ADDR_STEP"); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && sramWeN)) else $error("AST_DONE_IDLE"); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !arm) |=> done) else $error("AST_DONE_HOLD"); // R6

  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (&sramAddr)) else $error("AST_OVF_SAT"); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !arm) |=> overflow) else $error("AST_OVF_HOLD"); // R8

endmodule

bind still_capture still_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .arm      (arm),
  .sramAddr (sramAddr),
  .sramWeN  (sramWeN),
  .busy     (busy),
  .done     (done),
  .overflow (overflow)
);

// File: tb/sim_still_capture.sv
`timescale 1ns/1ps
module sim_still_capture;

  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int MAXA   = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 1'b0;
  logic decimate = 1'b0;
  logic vsyncIn = 1'b1;
  logic hrefIn = 1'b0;
  logic [DATA_W-1:0] pixData = '0;
  logic [ADDR_W-1:0] sramAddr;
  logic [DATA_W-1:0] sramData;
  logic sramWeN, busy, done, overflow;

  always #5 clk = ~clk;

  still_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .arm(arm), .decimate(decimate),
    .vsyncIn(vsyncIn), .hrefIn(hrefIn), .pixData(pixData),
    .sramAddr(sramAddr), .sramData(sramData), .sramWeN(sramWeN),
    .busy(busy), .done(done), .overflow(overflow)
  );

  int errors = 0;
  int checks = 0;
  logic [DATA_W-1:0] expData [0:1023];
  int expCnt = 0;
  int wrIdx = 0;
  int badWrites = 0;
  int firstBadAct = 0;
  int firstBadExp = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expAddr(input int idx);
    return (idx > MAXA) ? MAXA : idx;
  endfunction

  // SRAM model: compare every write against the expected stream.
  always @(negedge clk) begin
    if (rstN && !sramWeN) begin
      if (wrIdx >= expCnt) begin
        if (badWrites == 0) begin firstBadAct = wrIdx; firstBadExp = expCnt; end
        badWrites++;
      end else if (sramData != expData[wrIdx] || int'(sramAddr) != expAddr(wrIdx)) begin
        if (badWrites == 0) begin
          firstBadAct = int'(sramAddr) * 256 + int'(sramData);
          firstBadExp = expAddr(wrIdx) * 256 + int'(expData[wrIdx]);
        end
        badWrites++;
      end
      wrIdx++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doArm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic startFrameBook();
    expCnt = 0; wrIdx = 0; badWrites = 0;
  endtask

  task automatic sendLine(input int n, input bit store, input int gap);
    hrefIn = 1'b1;
    for (int k = 0; k < n; k++) begin
      pixData = DATA_W'($urandom);
      if (store) begin expData[expCnt] = pixData; expCnt++; end
      tick(2);
    end
    hrefIn = 1'b0;
    pixData = '0;
    tick(gap);
  endtask

  task automatic runFrame(input int nLines, input int minL, input int maxL,
                          input bit dec, input int armAfter);
    tick(4);
    vsyncIn = 1'b0;
    tick(6);
    for (int i = 0; i < nLines; i++) begin
      int len;
      len = minL + int'($urandom % (maxL - minL + 1));
      sendLine(len, !dec || (i % 2 == 0), 4 + int'($urandom % 8));
      if (i == armAfter) doArm();
    end
    vsyncIn = 1'b1;
    tick(8);
  endtask

  task automatic frameChecks(input string req);
    check(badWrites == 0, req, "write address/data stream", firstBadAct, firstBadExp);
    check(wrIdx == expCnt, "R3", "write count", wrIdx, expCnt);
    check(done && !busy, "R5", "done set, busy clear at frame end",
          int'({done, busy}), 2);
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    check(!busy && !done && !overflow && sramWeN && sramAddr == '0, "R1",
          "reset state {busy,done,ovf,weN}", int'({busy, done, overflow, sramWeN}), 1);
    rstN = 1'b1;
    tick(3);

    // Frame A: directed, stray line before vsync falls.
    startFrameBook();
    decimate = 1'b0;
    doArm();
    check(busy && sramAddr == '0, "R2", "busy after arm", int'(busy), 1);
    sendLine(5, 1'b0, 6);           // vsync still high: must be ignored
    tick(4);
    vsyncIn = 1'b0;
    tick(6);
    for (int i = 0; i < 4; i++) sendLine(16, 1'b1, 4);
    vsyncIn = 1'b1;
    tick(8);
    check(wrIdx == 64, "R2", "stray pre-frame line not stored", wrIdx, 64);
    frameChecks("R4");
    check(int'(sramAddr) == 64, "R4", "final address after 64 bytes", int'(sramAddr), 64);

    // After done: line activity must not write, done holds.
    sendLine(10, 1'b0, 6);
    tick(20);
    check(wrIdx == 64, "R5", "no writes after done", wrIdx, 64);
    check(done == 1'b1, "R6", "done held until arm", int'(done), 1);

    // Frame B: decimation latched at arm, mode flipped afterwards, arm mid-frame.
    startFrameBook();
    decimate = 1'b1;
    doArm();
    decimate = 1'b0;
    check(!done, "R6", "done cleared by arm", int'(done), 0);
    runFrame(7, 1, 40, 1'b1, 2);
    frameChecks("R7");
    check(int'(sramAddr) == expCnt, "R6", "mid-frame arm did not clear address",
          int'(sramAddr), expCnt);

    // Frame C: overflow on a small memory.
    startFrameBook();
    doArm();
    tick(4);
    vsyncIn = 1'b0;
    tick(6);
    for (int i = 0; i < 6; i++) sendLine(100, 1'b1, 5);
    vsyncIn = 1'b1;
    tick(8);
    frameChecks("R8");
    check(overflow == 1'b1, "R8", "overflow flag", int'(overflow), 1);
    check(int'(sramAddr) == MAXA, "R8", "address saturated", int'(sramAddr), MAXA);

    // Frame D: arm clears overflow; single-byte line and random lines.
    startFrameBook();
    doArm();
    check(!overflow && sramAddr == '0, "R2", "arm clears overflow/address",
          int'(overflow), 0);
    tick(4);
    vsyncIn = 1'b0;
    tick(6);
    sendLine(1, 1'b1, 2);
    sendLine(1, 1'b1, 3);
    for (int i = 0; i < 4; i++) sendLine(1 + int'($urandom % 30), 1'b1, 4);
    vsyncIn = 1'b1;
    tick(8);
    frameChecks("R3");

    // Frame E: random, no decimation, both modes of line length.
    startFrameBook();
    decimate = 1'b0;
    doArm();
    runFrame(6, 2, 25, 1'b0, 99);
    frameChecks("R4");
    check(overflow == 1'b0, "R8", "no overflow on small frame", int'(overflow), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule